// File: doc/BRIEF.md
# Core Halt-State Wake Controller

This block follows the power state of a single processor core as it moves between normal execution and the halt power-down state. A halt strobe parks the core. Any one of five wake pulses brings it back to execution: management interrupt, init, NMI, INTR or a bus interrupt message. Reset forces the initialised active state at once. An active-low stop-clock request moves the core into a stop-grant substate. There are two such substates, and each one records where it was entered from. When stop-clock is released, the core goes back to that origin, so a core that was halted stays halted.

The block also supports a management-interrupt handler. When a management interrupt wakes a halted core, the block sets a flag that tells the handler the core came from halt. When the handler signals its return, an accompanying select bit chooses whether the core resumes execution or goes back to halt. The state code is exported, together with a clock-gate enable that is high in every state except active.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A high `rst` at a clock edge puts the state at 2'b00 (active) and clears `smi_from_halt`. It takes priority over every other input, in every state.
- R2: In active (2'b00), with `stop_clk_n` high, no return strobe and no wake pulse, a `halt_stb` moves the state to 2'b01 (halt).
- R3: In halt, a pulse on any one of `smi_pulse`, `init_pulse`, `nmi_pulse`, `intr_pulse` or `bus_msg_pulse` moves the state to active on the next edge.
- R4: In active, if a wake pulse arrives in the same cycle as `halt_stb`, the wake wins and the state stays active.
- R5: In active, a low `stop_clk_n` moves the state to 2'b10 (stop-grant from active). This has priority over halt and return strobes. In 2'b10, a high `stop_clk_n` returns the state to active.
- R6: In halt, a low `stop_clk_n` with no wake pulse moves the state to 2'b11 (stop-grant from halt). A high `stop_clk_n` in 2'b11 returns the state to halt, not to active.
- R7: In halt, a wake pulse wins over a low `stop_clk_n` in the same cycle, and the state goes to active.
- R8: In either stop-grant state, wake pulses, `halt_stb` and the return strobe have no effect. The state holds while `stop_clk_n` stays low.
- R9: In active with `stop_clk_n` high, `smi_ret_stb` moves the state to halt if `smi_ret_to_halt` is 1, and keeps it active otherwise. This takes priority over `halt_stb`. In halt, `smi_ret_stb` and `halt_stb` have no effect.
- R10: `smi_from_halt` is set when `smi_pulse` is seen in halt. It is cleared when `smi_pulse` or `smi_ret_stb` is seen in active. In all other cases it holds its value.
- R11: `clk_gate_en` is 1 exactly when the state code is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_stb | input | 1 | Halt instruction strobe |
| smi_pulse | input | 1 | Management interrupt wake pulse |
| init_pulse | input | 1 | Init wake pulse |
| nmi_pulse | input | 1 | NMI wake pulse |
| intr_pulse | input | 1 | INTR wake pulse |
| bus_msg_pulse | input | 1 | Bus interrupt message wake pulse |
| stop_clk_n | input | 1 | Active-low stop-clock request |
| smi_ret_stb | input | 1 | Management handler return strobe |
| smi_ret_to_halt | input | 1 | Return target select: 1 means halt, 0 means active |
| pwr_state | output | 2 | 00 active, 01 halt, 10 stop-grant from active, 11 stop-grant from halt |
| clk_gate_en | output | 1 | Clock gate enable, high outside active |
| smi_from_halt | output | 1 | The management interrupt was taken from halt |

## Verification
The collisions that matter are a wake pulse together with a halt strobe in active, and a wake pulse together with stop-clock assertion in halt. The bench produces both by sweeping every combination of the ten inputs from each of the four states. Each of these states is reached once with the halt-origin flag clear and once with it set. After every applied cycle, the bench compares the state code, the gate enable and the flag against a model built from the priority order in the requirements.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_stb,
  input  logic       smi_pulse,
  input  logic       init_pulse,
  input  logic       nmi_pulse,
  input  logic       intr_pulse,
  input  logic       bus_msg_pulse,
  input  logic       stop_clk_n,
  input  logic       smi_ret_stb,
  input  logic       smi_ret_to_halt,
  output logic [1:0] pwr_state,
  output logic       clk_gate_en,
  output logic       smi_from_halt
);

  localparam logic [1:0] ST_RUN  = 2'b00;
  localparam logic [1:0] ST_HALT = 2'b01;
  localparam logic [1:0] ST_SGR  = 2'b10;
  localparam logic [1:0] ST_SGH  = 2'b11;

  logic [1:0] cur, nxt;
  logic       flag, flag_nxt;
  logic       wake;

  assign wake = smi_pulse | init_pulse | nmi_pulse | intr_pulse | bus_msg_pulse;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_RUN: begin
        if (!stop_clk_n)            nxt = ST_SGR;
        else if (smi_ret_stb)       nxt = smi_ret_to_halt ? ST_HALT : ST_RUN;
        else if (halt_stb && !wake) nxt = ST_HALT;
      end
      ST_HALT: begin
        if (wake)                   nxt = ST_RUN;
        else if (!stop_clk_n)       nxt = ST_SGH;
      end
      ST_SGR:  if (stop_clk_n)      nxt = ST_RUN;
      default: if (stop_clk_n)      nxt = ST_HALT;
    endcase
  end

  always_comb begin
    flag_nxt = flag;
    if (cur == ST_HALT && smi_pulse)                     flag_nxt = 1'b1;
    else if (cur == ST_RUN && (smi_pulse || smi_ret_stb)) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= ST_RUN;
      flag <= 1'b0;
    end else begin
      cur  <= nxt;
      flag <= flag_nxt;
    end
  end

  assign pwr_state     = cur;
  assign clk_gate_en   = (cur != ST_RUN);
  assign smi_from_halt = flag;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pwr_state == 2'b00 && !smi_from_halt));

  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && stop_clk_n && !smi_ret_stb && halt_stb && !wake)
      |=> pwr_state == 2'b01);

  assert_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b01 && wake) |=> pwr_state == 2'b00);

  assert_wake_beats_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && stop_clk_n && !smi_ret_stb && halt_stb && wake)
      |=> pwr_state == 2'b00);

  assert_sg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_state[1] && !stop_clk_n) |=> $stable(pwr_state));

  assert_sgh_back_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b11 && stop_clk_n) |=> pwr_state == 2'b01);

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_from_halt) |-> ($past(pwr_state) == 2'b01 && $past(smi_pulse)));

  assert_gate_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_gate_en) |-> $past(pwr_state) == 2'b00);

endmodule

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
  logic clk = 1'b0;
  logic rst, halt_stb, smi_pulse, init_pulse, nmi_pulse, intr_pulse, bus_msg_pulse;
  logic stop_clk_n, smi_ret_stb, smi_ret_to_halt;
  logic [1:0] pwr_state;
  logic clk_gate_en, smi_from_halt;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_st;
  logic       m_fh;

  always #2.5 clk = ~clk;

  halt_wake_ctrl u_halt_wake_ctrl (
    .clk(clk), .rst(rst), .halt_stb(halt_stb), .smi_pulse(smi_pulse),
    .init_pulse(init_pulse), .nmi_pulse(nmi_pulse), .intr_pulse(intr_pulse),
    .bus_msg_pulse(bus_msg_pulse), .stop_clk_n(stop_clk_n),
    .smi_ret_stb(smi_ret_stb), .smi_ret_to_halt(smi_ret_to_halt),
    .pwr_state(pwr_state), .clk_gate_en(clk_gate_en), .smi_from_halt(smi_from_halt)
  );

  // vector bits: 0 halt, 1 smi, 2 init, 3 nmi, 4 intr, 5 bus, 6 stop_clk_n, 7 ret, 8 ret_to_halt, 9 rst
  function automatic string tag_of(logic [1:0] s, logic [9:0] v);
    logic wk;
    wk = |v[5:1];
    if (v[9])                          return "R1";
    if (s[1])                          return v[6] ? (s[0] ? "R6" : "R5") : "R8";
    if (s == 2'b01)                    return wk ? (v[6] ? "R3" : "R7") : (v[6] ? "R9" : "R6");
    if (!v[6])                         return "R5";
    if (v[7])                          return "R9";
    if (v[0] && wk)                    return "R4";
    if (v[0])                          return "R2";
    return "R10";
  endfunction

  task automatic apply(input logic [9:0] v);
    logic wk;
    halt_stb = v[0]; smi_pulse = v[1]; init_pulse = v[2]; nmi_pulse = v[3];
    intr_pulse = v[4]; bus_msg_pulse = v[5]; stop_clk_n = v[6];
    smi_ret_stb = v[7]; smi_ret_to_halt = v[8]; rst = v[9];
    wk = |v[5:1];
    if (v[9]) begin
      m_st = 2'b00; m_fh = 1'b0;
    end else begin
      if (m_st == 2'b01 && v[1]) m_fh = 1'b1;
      else if (m_st == 2'b00 && (v[1] || v[7])) m_fh = 1'b0;
      case (m_st)
        2'b00: m_st = !v[6] ? 2'b10 : v[7] ? {1'b0, v[8]} : (v[0] && !wk) ? 2'b01 : 2'b00;
        2'b01: m_st = wk ? 2'b00 : !v[6] ? 2'b11 : 2'b01;
        2'b10: m_st = v[6] ? 2'b00 : 2'b10;
        default: m_st = v[6] ? 2'b01 : 2'b11;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic check(input string req);
    checks++;
    if (pwr_state !== m_st || clk_gate_en !== (m_st != 2'b00) || smi_from_halt !== m_fh) begin
      errors++;
      $display("FAIL %s: state=%b gate=%b flag=%b expected state=%b gate=%b flag=%b (R11 gate)",
               req, pwr_state, clk_gate_en, smi_from_halt, m_st, (m_st != 2'b00), m_fh);
    end
  endtask

  localparam logic [9:0] IDLE = 10'b0001000000;

  initial begin
    fork
      begin
        @(negedge clk);
        apply(IDLE | 10'h200);
        check("R1");
        for (int fh = 0; fh < 2; fh++) begin
          for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 1024; v++) begin
              apply(IDLE | 10'h200);
              if (fh == 1) begin
                apply(IDLE | 10'h001);
                apply(IDLE | 10'h002);
              end
              if (s == 1 || s == 3) apply(IDLE | 10'h001);
              if (s >= 2) apply(10'h000);
              check(s >= 2 ? (s == 3 ? "R6" : "R5") : (fh == 1 ? "R10" : "R2"));
              apply(v[9:0]);
              check(tag_of(s[1:0], v[9:0]));
            end
          end
        end
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule